// File: doc/BRIEF.md
# Power-Good and Load-Disconnect Monitor

This block watches one powered output port and produces two status results from it. The first is a power-good flag. It rises only after the output has stayed inside its window for a long qualifying time. It drops after a much shorter time outside the window. The second is a load-disconnect fault. Once the port is good, the block measures how long the load current stays below a small threshold. If the current stays low for long enough, the block latches an active-low fault flag and asks the power switch to open.

All timing is counted in ticks of a 0.1 ms strobe, so every delay is a tick-count parameter. The analog comparators sit outside the block and deliver two digital flags: "output inside the window", with hysteresis already applied, and "current below the disconnect threshold".

A strap input selects how a fault is recovered. With the detection stage in use, the block asks for a new signature detection straight away, and the next valid detection clears the fault. With detection bypassed, the switch stays open until the enable input is taken low.

Top module: `pwrgood_zc_monitor`

## Requirements
- R1: `pgood_o` rises one cycle after the clock edge that samples the PG_ON_TICKS-th consecutive tick with `in_window_i` high. The default is 880 ticks, which is 88 ms.
- R2: `pgood_o` falls one cycle after the edge that samples the PG_OFF_TICKS-th consecutive tick with `in_window_i` low. The default is 14 ticks, which is 1.4 ms.
- R3: Any cycle in which `in_window_i` holds the value that keeps the present `pgood_o` state restarts the pending R1 or R2 count from zero.
- R4: The disconnect timer runs only while `zc_en_i`, `pgood_o` and `enable_i` are all high and `sw_off_o` is low. Whenever that condition is false, both disconnect counters are cleared and no fault can be raised.
- R5: Suppose ZC_DEL_TICKS ticks with `below_zc_i` high accumulate without a reset under R6. The default is 3500 ticks, which is 350 ms. In the cycle after the edge that samples the last of those ticks, `zc_flag_n_o` goes low (0 means fault) and `sw_off_o` goes high.
- R6: Within a low-current interval, ZC_DEG_TICKS consecutive ticks with `below_zc_i` low clear the accumulated count. The default is 100 ticks, which is 10 ms. A shorter run of such ticks only pauses the count, and the count resumes from its held value.
- R7: With `det_dis_i` low, a fault raises `redetect_o` for exactly one cycle, in the same cycle that `sw_off_o` rises. A later `det_valid_i` pulse drives `zc_flag_n_o` high and `sw_off_o` low one cycle later.
- R8: With `det_dis_i` high, a fault never raises `redetect_o`, and `det_valid_i` has no effect. `sw_off_o` stays high until `enable_i` is sampled low. That same sample also drives `zc_flag_n_o` high.
- R9: While `zc_en_i` is low, `zc_flag_n_o` is high.
- R10: `enable_i` sampled low clears `sw_off_o` on the next cycle in either strap setting.
- R11: After reset, `pgood_o`, `sw_off_o` and `redetect_o` are 0 and `zc_flag_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle strobe every 0.1 ms |
| in_window_i | input | 1 | Output is within the power-good window (hysteresis applied externally) |
| below_zc_i | input | 1 | Load current below the disconnect threshold |
| zc_en_i | input | 1 | Enables disconnect checking |
| det_dis_i | input | 1 | Strap: detection bypassed |
| det_valid_i | input | 1 | Pulse: a valid signature was detected |
| enable_i | input | 1 | Port enable |
| pgood_o | output | 1 | Delayed power-good |
| zc_flag_n_o | output | 1 | Latched disconnect fault, active low |
| sw_off_o | output | 1 | Request to open the power switch |
| redetect_o | output | 1 | One-cycle request to restart detection |

## Verification
Every result is due one cycle after the rising edge that samples the qualifying input. For `pgood_o`, that input is the last tick of the window count. For `zc_flag_n_o`, `sw_off_o` and `redetect_o`, it is the expiring tick or the clearing input.

The bench drives inputs on falling edges and keeps a behavioural model that advances on each rising edge. It compares every output on the next falling edge, so each check lands exactly in the cycle the result is due. The directed phases run with a tick in every cycle. This turns each delay into an exact cycle count that the bench states, and it samples one cycle before and at the due cycle.

// File: rtl/pgdm_pkg.sv
package pgdm_pkg;

  // Phase of the disconnect timer.
  typedef enum logic [1:0] {
    ZC_IDLE   = 2'd0,
    ZC_LOW    = 2'd1,
    ZC_GLITCH = 2'd2
  } zc_phase_e;

  // State held by the fault controller.
  typedef struct packed {
    logic latched;
    logic off;
    logic redetect;
  } fault_state_t;

endpackage

// File: rtl/pgdm_rst_sync.sv
module pgdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pgdm_window_filter.sv
module pgdm_window_filter #(
  parameter int unsigned ON_TICKS  = 880,
  parameter int unsigned OFF_TICKS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic win_i,
  output logic pg_o
);
  localparam int unsigned MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);

  logic          pg_q, pg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          toward_change;
  logic [CW-1:0] last_cnt;

  // One counter serves both directions; it is cleared on every flip.
  always_comb begin
    pg_d          = pg_q;
    cnt_d         = cnt_q;
    toward_change = pg_q ? !win_i : win_i;
    last_cnt      = pg_q ? OFF_LAST : ON_LAST;
    if (!toward_change) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == last_cnt) begin
        pg_d  = !pg_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      pg_q  <= pg_d;
      cnt_q <= cnt_d;
    end
  end

  assign pg_o = pg_q;
endmodule

// File: rtl/pgdm_zc_timer.sv
module pgdm_zc_timer
  import pgdm_pkg::*;
#(
  parameter int unsigned DEL_TICKS = 3500,
  parameter int unsigned DEG_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic arm_i,
  input  logic below_i,
  output logic expire_o
);
  localparam int unsigned DW = $clog2(DEL_TICKS + 1);
  localparam int unsigned GW = $clog2(DEG_TICKS + 1);
  localparam logic [DW-1:0] DEL_LAST = DW'(DEL_TICKS - 1);
  localparam logic [GW-1:0] DEG_LAST = GW'(DEG_TICKS - 1);

  zc_phase_e     phase_q, phase_d;
  logic [DW-1:0] del_q, del_d;
  logic [GW-1:0] deg_q, deg_d;

  always_comb begin
    phase_d  = phase_q;
    del_d    = del_q;
    deg_d    = deg_q;
    expire_o = 1'b0;
    if (!arm_i) begin
      phase_d = ZC_IDLE;
      del_d   = '0;
      deg_d   = '0;
    end else if (tick_i) begin
      if (below_i) begin
        deg_d = '0;
        if (del_q == DEL_LAST) begin
          expire_o = 1'b1;
          phase_d  = ZC_IDLE;
          del_d    = '0;
        end else begin
          del_d   = del_q + DW'(1);
          phase_d = ZC_LOW;
        end
      end else if (phase_q != ZC_IDLE) begin
        // current back above threshold inside a low-current interval
        if (deg_q == DEG_LAST) begin
          phase_d = ZC_IDLE;
          del_d   = '0;
          deg_d   = '0;
        end else begin
          deg_d   = deg_q + GW'(1);
          phase_d = ZC_GLITCH;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ZC_IDLE;
      del_q   <= '0;
      deg_q   <= '0;
    end else begin
      phase_q <= phase_d;
      del_q   <= del_d;
      deg_q   <= deg_d;
    end
  end
endmodule

// File: rtl/pgdm_fault_ctl.sv
module pgdm_fault_ctl
  import pgdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic det_dis_i,
  input  logic det_valid_i,
  input  logic enable_i,
  input  logic zc_en_i,
  output logic zc_n_o,
  output logic off_o,
  output logic redetect_o
);
  fault_state_t st_q, st_d;

  always_comb begin
    st_d          = st_q;
    st_d.redetect = 1'b0;
    if (expire_i) begin
      st_d.latched  = 1'b1;
      st_d.off      = 1'b1;
      st_d.redetect = !det_dis_i;
    end else begin
      if (!enable_i) st_d.off = 1'b0;
      if (det_dis_i && !enable_i) st_d.latched = 1'b0;
      if (!det_dis_i && det_valid_i) begin
        st_d.latched = 1'b0;
        st_d.off     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign zc_n_o     = !(st_q.latched && zc_en_i);
  assign off_o      = st_q.off;
  assign redetect_o = st_q.redetect;
endmodule

// File: rtl/pwrgood_zc_monitor.sv
module pwrgood_zc_monitor #(
  parameter int unsigned PG_ON_TICKS     = 880,
  parameter int unsigned PG_OFF_TICKS    = 14,
  parameter int unsigned ZC_DEL_TICKS    = 3500,
  parameter int unsigned ZC_DEG_TICKS    = 100,
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic in_window_i,
  input  logic below_zc_i,
  input  logic zc_en_i,
  input  logic det_dis_i,
  input  logic det_valid_i,
  input  logic enable_i,
  output logic pgood_o,
  output logic zc_flag_n_o,
  output logic sw_off_o,
  output logic redetect_o
);
  logic rst_sync_n;
  logic pg;
  logic arm;
  logic expire;
  logic off;

  pgdm_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pgdm_window_filter #(.ON_TICKS(PG_ON_TICKS), .OFF_TICKS(PG_OFF_TICKS)) u_win (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick_i),
    .win_i  (in_window_i),
    .pg_o   (pg)
  );

  assign arm = zc_en_i && pg && enable_i && !off;

  pgdm_zc_timer #(.DEL_TICKS(ZC_DEL_TICKS), .DEG_TICKS(ZC_DEG_TICKS)) u_zc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (tick_i),
    .arm_i    (arm),
    .below_i  (below_zc_i),
    .expire_o (expire)
  );

  pgdm_fault_ctl u_flt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .expire_i    (expire),
    .det_dis_i   (det_dis_i),
    .det_valid_i (det_valid_i),
    .enable_i    (enable_i),
    .zc_en_i     (zc_en_i),
    .zc_n_o      (zc_flag_n_o),
    .off_o       (off),
    .redetect_o  (redetect_o)
  );

  assign pgood_o  = pg;
  assign sw_off_o = off;
endmodule

// File: rtl/pwrgood_zc_monitor_chk.sv
module pwrgood_zc_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic in_window_i,
  input logic below_zc_i,
  input logic zc_en_i,
  input logic det_dis_i,
  input logic det_valid_i,
  input logic enable_i,
  input logic pgood_o,
  input logic sw_off_o,
  input logic redetect_o
);
  AST_PG_RISE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> ($past(in_window_i) && $past(tick_i))); // R1
  AST_PG_FALL_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood_o) |-> (!$past(in_window_i) && $past(tick_i))); // R2
  AST_FAULT_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_off_o) |-> ($past(pgood_o) && $past(zc_en_i) && $past(enable_i))); // R4
  AST_FAULT_ON_LOW_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_off_o) |-> ($past(below_zc_i) && $past(tick_i))); // R5
  AST_REDETECT_MATCHES_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_off_o) |-> (redetect_o == !$past(det_dis_i))); // R7
  AST_REDETECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    redetect_o |=> !redetect_o); // R7
  AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sw_off_o) && $past(enable_i) && !(!$past(det_dis_i) && $past(det_valid_i)))
      |-> sw_off_o); // R8
endmodule

bind pwrgood_zc_monitor pwrgood_zc_monitor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_i      (tick_i),
  .in_window_i (in_window_i),
  .below_zc_i  (below_zc_i),
  .zc_en_i     (zc_en_i),
  .det_dis_i   (det_dis_i),
  .det_valid_i (det_valid_i),
  .enable_i    (enable_i),
  .pgood_o     (pgood_o),
  .sw_off_o    (sw_off_o),
  .redetect_o  (redetect_o)
);

// File: tb/pwrgood_zc_monitor_tb.sv
module pwrgood_zc_monitor_tb;
  localparam int ON  = 20;
  localparam int OFF = 4;
  localparam int DEL = 40;
  localparam int DEG = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, win, below, zc_en, det_dis, det_valid, enable;
  logic pgood, zc_n, sw_off, redet;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = !clk;

  pwrgood_zc_monitor #(
    .PG_ON_TICKS(ON), .PG_OFF_TICKS(OFF), .ZC_DEL_TICKS(DEL), .ZC_DEG_TICKS(DEG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .in_window_i(win),
    .below_zc_i(below), .zc_en_i(zc_en), .det_dis_i(det_dis),
    .det_valid_i(det_valid), .enable_i(enable), .pgood_o(pgood),
    .zc_flag_n_o(zc_n), .sw_off_o(sw_off), .redetect_o(redet)
  );

  // Behavioural model of the requirements, advanced on each rising edge.
  logic m_pg, m_lat, m_off, m_rd;
  int   m_wc, m_low, m_hi;
  bit   m_int;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pg = 0; m_lat = 0; m_off = 0; m_rd = 0;
      m_wc = 0; m_low = 0; m_hi = 0; m_int = 0;
    end else begin
      bit arm, ex;
      arm = zc_en && m_pg && enable && !m_off;
      ex  = 0;
      if (!arm) begin
        m_low = 0; m_hi = 0; m_int = 0;
      end else if (tick) begin
        if (below) begin
          m_hi = 0;
          if (m_low == DEL - 1) begin ex = 1; m_low = 0; m_int = 0; end
          else begin m_low++; m_int = 1; end
        end else if (m_int) begin
          m_hi++;
          if (m_hi == DEG) begin m_low = 0; m_hi = 0; m_int = 0; end
        end
      end
      if ((m_pg && win) || (!m_pg && !win)) m_wc = 0;
      else if (tick) begin
        if (m_wc == (m_pg ? OFF : ON) - 1) begin m_pg = !m_pg; m_wc = 0; end
        else m_wc++;
      end
      m_rd = 0;
      if (ex) begin
        m_lat = 1; m_off = 1; m_rd = !det_dis;
      end else begin
        if (!enable) m_off = 0;
        if (det_dis && !enable) m_lat = 0;
        if (!det_dis && det_valid) begin m_lat = 0; m_off = 0; end
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R1/R2/R3 pgood", pgood, m_pg);
    chk("R5/R7/R8/R9 zc_flag_n", zc_n, !(m_lat && zc_en));
    chk("R5/R7/R8/R10 sw_off", sw_off, m_off);
    chk("R7/R8 redetect", redet, m_rd);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  task automatic pulse_valid();
    det_valid = 1; step(1); det_valid = 0;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 0; tick = 0; win = 0; below = 0; zc_en = 0;
    det_dis = 0; det_valid = 0; enable = 0;
    step(3);
    rst_n = 1;
    step(4);
    chk("R11 pgood", pgood, 1'b0);
    chk("R11 zc_flag_n", zc_n, 1'b1);
    chk("R11 sw_off", sw_off, 1'b0);
    chk("R11 redetect", redet, 1'b0);

    // power-good qualification with a bounce
    tick = 1; enable = 1; zc_en = 1; win = 1;
    step(10);
    win = 0; step(1); win = 1;
    step(ON - 1);
    chk("R3 pgood count restarted", pgood, 1'b0);
    step(1);
    chk("R1 pgood after on delay", pgood, 1'b1);

    // low-current interval with a short recovery glitch
    below = 1; step(30);
    below = 0; step(DEG - 1);
    below = 1; step(9);
    chk("R6 short glitch held count", zc_n, 1'b1);
    step(1);
    chk("R5 zc_flag_n latched", zc_n, 1'b0);
    chk("R5 sw_off set", sw_off, 1'b1);
    chk("R7 redetect pulse", redet, 1'b1);
    below = 0; step(1);
    chk("R7 redetect single cycle", redet, 1'b0);
    chk("R7 still latched", zc_n, 1'b0);
    pulse_valid();
    chk("R7 valid clears flag", zc_n, 1'b1);
    chk("R7 valid clears sw_off", sw_off, 1'b0);

    // long recovery resets the timer
    below = 1; step(20);
    below = 0; step(DEG);
    below = 1; step(DEL - 1);
    chk("R6 long recovery reset count", zc_n, 1'b1);
    step(1);
    chk("R5 fault after full count", zc_n, 1'b0);
    below = 0; step(1);
    pulse_valid();

    // strap high: no redetect, held until enable low
    det_dis = 1; below = 1; step(DEL);
    chk("R8 sw_off set", sw_off, 1'b1);
    chk("R8 no redetect", redet, 1'b0);
    below = 0; pulse_valid(); step(1);
    chk("R8 valid ignored sw_off", sw_off, 1'b1);
    chk("R8 valid ignored flag", zc_n, 1'b0);
    enable = 0; step(1);
    chk("R10 enable low clears sw_off", sw_off, 1'b0);
    chk("R8 enable low clears flag", zc_n, 1'b1);
    enable = 1; det_dis = 0;

    // checking disabled
    zc_en = 0; below = 1; step(DEL + 20);
    chk("R9 flag released while disabled", zc_n, 1'b1);
    chk("R4 no switch-off while disabled", sw_off, 1'b0);

    // power-good loss and no arming without it
    below = 0; win = 0; step(OFF - 1);
    chk("R2 pgood before off delay", pgood, 1'b1);
    step(1);
    chk("R2 pgood after off delay", pgood, 1'b0);
    zc_en = 1; below = 1; step(DEL + 20);
    chk("R4 no fault without pgood", zc_n, 1'b1);

    // constrained random phase
    for (int c = 0; c < 20000; c++) begin
      step(1);
      tick      = ($urandom % 4) != 0;
      det_valid = ($urandom % 200) == 0;
      if ($urandom % 40 == 0)   win     = !win;
      if ($urandom % 15 == 0)   below   = !below;
      if ($urandom % 400 == 0)  enable  = !enable;
      if ($urandom % 1500 == 0) det_dis = !det_dis;
      if ($urandom % 800 == 0)  zc_en   = !zc_en;
    end
    step(2);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule